// File: doc/BRIEF.md
# NAND Access Width Adapter

This block sits between a 32-bit processor register port and the I/O bus of a NAND flash device that is either 8 or 16 bits wide. Each chip select owns a register block, repeated at a fixed stride, and each block holds three small windows: command, address and data. A processor access of one, two or four bytes that lands in one of these windows becomes a sequence of device cycles. Command cycles raise the command latch enable (CLE), address cycles raise the address latch enable (ALE), and data cycles raise neither. The number and width of the cycles depend on the access size and on the width bit configured for the target chip select.

For reads, the block gathers the bytes or halfwords returned by the device back into one 32-bit word. A request is taken only while the block is idle. `busy` covers the whole device sequence, and a one-clock `done` pulse marks the end of each request. Accesses outside the windows, or to chip selects not set up as NAND, produce no device cycles. A narrow access outside the windows is flagged as an error.

Top module: `nand_width_adapter`

## Requirements
- R1: After reset, `busy`, `done`, `acc_err`, `nand_cle`, `nand_ale` and `nand_io_oe` are 0. `nand_we_n`, `nand_re_n` and every bit of `nand_ce_n` are 1. `rd_data` is 0.
- R2: Chip select i owns the command window at byte offsets 0x7C..0x7F + 0x30*i, the address window at 0x80..0x83 + 0x30*i and the data window at 0x84..0x87 + 0x30*i. During that chip select's device cycles, only `nand_ce_n[i]` is low.
- R3: Every cycle of a command-window access has CLE high and ALE low. Every cycle of an address-window access has ALE high and CLE low. Data-window cycles have both low.
- R4: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes. On an 8-bit chip select (width bit 0), a write produces 1, 2 or 4 cycles. Cycle k drives write-data byte k on `nand_io_out[7:0]`, with bits [15:8] zero, so the least significant byte goes first.
- R5: On an 8-bit chip select, a data read produces 1, 2 or 4 cycles. The byte read in cycle k from `nand_io_in[7:0]` lands in `rd_data[8k+7:8k]`, and all higher bits are zero.
- R6: On a 16-bit chip select (width bit 1), a 1- or 2-byte write produces one cycle carrying write data [15:0]. A 4-byte write produces two cycles: [15:0] first, then [31:16].
- R7: On a 16-bit chip select, a 2-byte read returns the halfword in `rd_data[15:0]`. A 4-byte read returns the first halfword in [15:0] and the second in [31:16]. A 1-byte read produces one cycle and returns only `nand_io_in[7:0]`. All bits not filled are zero.
- R8: No device cycle occurs, and `done` with `rd_data` = 0 follows on the next clock, in two cases: the chip select's 2-bit device-type field is not 2 (the NAND encoding), or the access is a read of a command or address window.
- R9: An access of size code 0 or 1 to any address outside the windows produces no device cycle and raises `acc_err` together with `done`. A 4-byte access there produces `done` without `acc_err`.
- R10: Each device cycle is one clock with the strobe low, followed by one clock with it high. `nand_we_n` is used for writes and `nand_re_n` for reads, and the two are never low together. A request of N cycles keeps `busy` high for 2N clocks, then `done` pulses for one clock. A request presented while `busy` is high is ignored. A request presented during the `done` clock is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Request strobe, taken while not busy |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte offset of the access |
| cpu_size | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| cpu_wdata | input | 32 | Write data |
| cs_type | input | 2*NUM_CS | Device-type field per chip select, 2 = NAND |
| cs_wide | input | NUM_CS | Device width per chip select, 1 = 16-bit |
| busy | output | 1 | Device sequence in progress |
| done | output | 1 | One-clock completion pulse |
| acc_err | output | 1 | Narrow access outside the windows, with done |
| rd_data | output | 32 | Assembled read word, valid with done |
| nand_ce_n | output | NUM_CS | Active-low chip enables |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_io_oe | output | 1 | I/O bus driven by the block |
| nand_io_out | output | 16 | I/O bus outbound value |
| nand_io_in | input | 16 | I/O bus inbound value |

## Verification
The completion of one request and the acceptance of the next can fall in the same clock. A new request is presented in exactly the clock where `done` is seen high, and `busy` must rise on the following clock. The test then judges two things: the read word of the first request is intact at its `done`, and the second request yields only its own device cycles, with the correct latch enable. A request raised in the middle of a sequence is also checked: the device must still see only the cycles of the first request.

// File: rtl/nwa_pkg.sv
package nwa_pkg;

   localparam int CPU_W = 32;
   localparam int IO_W  = 16;

   typedef enum logic [1:0] {
      WK_NONE = 2'd0,
      WK_CMD  = 2'd1,
      WK_ADR  = 2'd2,
      WK_DAT  = 2'd3
   } win_kind_e;

   typedef enum logic [1:0] {
      PH_IDLE    = 2'd0,
      PH_STROBE  = 2'd1,
      PH_RECOVER = 2'd2
   } phase_e;

   localparam logic [1:0] DEVTYPE_NAND = 2'd2;

   // device cycles needed for one processor access
   function automatic logic [2:0] beats_for(input logic [1:0] size, input logic wide);
      logic [2:0] n;
      if (wide) begin
         n = size[1] ? 3'd2 : 3'd1;
      end else begin
         case (size)
            2'd0:    n = 3'd1;
            2'd1:    n = 3'd2;
            default: n = 3'd4;
         endcase
      end
      return n;
   endfunction

endpackage

// File: rtl/nwa_window_decode.sv
module nwa_window_decode
   import nwa_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int NUM_CS     = 8,
   parameter int CS_W       = 3,
   parameter int WIN_BASE   = 'h60,
   parameter int WIN_STRIDE = 'h30,
   parameter int CMD_OFS    = 'h1C,
   parameter int ADR_OFS    = 'h20,
   parameter int DAT_OFS    = 'h24,
   parameter int WIN_SPAN   = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output win_kind_e         kind,
   output logic [CS_W-1:0]   cs_idx
);

   logic [31:0]       a_ext;
   logic [NUM_CS-1:0] hit_c;
   logic [NUM_CS-1:0] hit_a;
   logic [NUM_CS-1:0] hit_d;

   assign a_ext = 32'(addr);

   for (genvar i = 0; i < NUM_CS; i++) begin : g_blk
      localparam logic [31:0] BLK = 32'(WIN_BASE + i * WIN_STRIDE);
      localparam logic [31:0] C_LO = BLK + 32'(CMD_OFS);
      localparam logic [31:0] A_LO = BLK + 32'(ADR_OFS);
      localparam logic [31:0] D_LO = BLK + 32'(DAT_OFS);
      localparam logic [31:0] SPAN = 32'(WIN_SPAN);
      assign hit_c[i] = (a_ext >= C_LO) && (a_ext < C_LO + SPAN);
      assign hit_a[i] = (a_ext >= A_LO) && (a_ext < A_LO + SPAN);
      assign hit_d[i] = (a_ext >= D_LO) && (a_ext < D_LO + SPAN);
   end

   always_comb begin
      cs_idx = '0;
      for (int i = 0; i < NUM_CS; i++) begin
         if (hit_c[i] || hit_a[i] || hit_d[i]) cs_idx = CS_W'(i);
      end
      if (|hit_c)      kind = WK_CMD;
      else if (|hit_a) kind = WK_ADR;
      else if (|hit_d) kind = WK_DAT;
      else             kind = WK_NONE;
   end

endmodule

// File: rtl/nwa_lane_mux.sv
module nwa_lane_mux
   import nwa_pkg::*;
(
   input  logic [1:0]       lane,
   input  logic             wide,
   input  logic [CPU_W-1:0] wdata,
   output logic [IO_W-1:0]  io
);

   // 16-bit device: halfword per cycle; 8-bit device: byte per cycle, top lane zero
   always_comb begin
      if (wide) io = lane[0] ? wdata[31:16] : wdata[15:0];
      else      io = {8'h00, wdata[{lane, 3'b000} +: 8]};
   end

endmodule

// File: rtl/nwa_read_pack.sv
module nwa_read_pack
   import nwa_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cap,
   input  logic [1:0]       lane,
   input  logic             wide,
   input  logic             byte_only,
   input  logic [IO_W-1:0]  io_in,
   output logic [CPU_W-1:0] acc
);

   localparam int LANES = CPU_W / 8;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam bit LOW_HALF_BYTE = (g % 2) == 0;
      localparam bit FIRST_BYTE    = (g == 0);
      logic       en;
      logic [7:0] src;

      if (LOW_HALF_BYTE) begin : g_lo
         assign src = wide ? io_in[7:0] : io_in[7:0];
      end else begin : g_hi
         assign src = wide ? io_in[15:8] : io_in[7:0];
      end

      assign en = cap && (wide ? ((lane[0] == 1'(g / 2)) && (!byte_only || FIRST_BYTE))
                               : (lane == 2'(g)));

      always_ff @(posedge clk) begin
         if (!rst_n)   acc[8*g +: 8] <= '0;
         else if (clr) acc[8*g +: 8] <= '0;
         else if (en)  acc[8*g +: 8] <= src;
      end
   end

   // R10: a new request never coincides with a capture of the previous one
   p_clr_cap_excl_r10: assert property (@(posedge clk) disable iff (!rst_n) !(clr && cap));

endmodule

// File: rtl/nand_width_adapter.sv
module nand_width_adapter
   import nwa_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int NUM_CS     = 8,
   parameter int WIN_BASE   = 'h60,
   parameter int WIN_STRIDE = 'h30,
   parameter int CMD_OFS    = 'h1C,
   parameter int ADR_OFS    = 'h20,
   parameter int DAT_OFS    = 'h24,
   parameter int WIN_SPAN   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cpu_req,
   input  logic                cpu_wr,
   input  logic [ADDR_W-1:0]   cpu_addr,
   input  logic [1:0]          cpu_size,
   input  logic [31:0]         cpu_wdata,
   input  logic [2*NUM_CS-1:0] cs_type,
   input  logic [NUM_CS-1:0]   cs_wide,
   output logic                busy,
   output logic                done,
   output logic                acc_err,
   output logic [31:0]         rd_data,
   output logic [NUM_CS-1:0]   nand_ce_n,
   output logic                nand_cle,
   output logic                nand_ale,
   output logic                nand_we_n,
   output logic                nand_re_n,
   output logic                nand_io_oe,
   output logic [15:0]         nand_io_out,
   input  logic [15:0]         nand_io_in
);

   localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

   if (NUM_CS < 1 || NUM_CS > 16) begin : g_bad_cs
      $error("NUM_CS out of range");
   end
   if (ADDR_W < 8 || ADDR_W > 30) begin : g_bad_aw
      $error("ADDR_W out of range");
   end
   if (WIN_BASE + NUM_CS * WIN_STRIDE > (1 << ADDR_W)) begin : g_bad_span
      $error("chip-select blocks exceed the address range");
   end
   if (CMD_OFS + WIN_SPAN > ADR_OFS || ADR_OFS + WIN_SPAN > DAT_OFS ||
       DAT_OFS + WIN_SPAN > WIN_STRIDE) begin : g_bad_win
      $error("windows overlap or leave the block");
   end

   win_kind_e       dec_kind;
   logic [CS_W-1:0] dec_cs;

   nwa_window_decode #(
      .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .CS_W(CS_W),
      .WIN_BASE(WIN_BASE), .WIN_STRIDE(WIN_STRIDE),
      .CMD_OFS(CMD_OFS), .ADR_OFS(ADR_OFS), .DAT_OFS(DAT_OFS),
      .WIN_SPAN(WIN_SPAN)
   ) u_dec (
      .addr  (cpu_addr),
      .kind  (dec_kind),
      .cs_idx(dec_cs)
   );

   phase_e          phase;
   logic [1:0]      lane;
   logic [1:0]      last_lane;
   logic            wr_q;
   logic            wide_q;
   logic            byte_q;
   win_kind_e       kind_q;
   logic [CS_W-1:0] cs_q;
   logic [31:0]     wdata_q;
   logic            done_q;
   logic            err_q;

   logic       sel_nand;
   logic       sel_wide;
   logic       go;
   logic       act;
   logic [2:0] beats;

   assign sel_nand = cs_type[{dec_cs, 1'b0} +: 2] == DEVTYPE_NAND;
   assign sel_wide = cs_wide[dec_cs];
   assign go       = cpu_req && (phase == PH_IDLE);
   assign act      = (dec_kind != WK_NONE) && sel_nand && (cpu_wr || dec_kind == WK_DAT);
   assign beats    = beats_for(cpu_size, sel_wide);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         lane      <= '0;
         last_lane <= '0;
         wr_q      <= 1'b0;
         wide_q    <= 1'b0;
         byte_q    <= 1'b0;
         kind_q    <= WK_NONE;
         cs_q      <= '0;
         wdata_q   <= '0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         case (phase)
            PH_IDLE: begin
               if (go) begin
                  if (act) begin
                     phase     <= PH_STROBE;
                     lane      <= '0;
                     last_lane <= 2'(beats - 3'd1);
                     wr_q      <= cpu_wr;
                     wide_q    <= sel_wide;
                     byte_q    <= (cpu_size == 2'd0);
                     kind_q    <= dec_kind;
                     cs_q      <= dec_cs;
                     wdata_q   <= cpu_wdata;
                  end else begin
                     done_q <= 1'b1;
                     err_q  <= !cpu_size[1] && (dec_kind == WK_NONE);
                  end
               end
            end
            PH_STROBE: phase <= PH_RECOVER;
            PH_RECOVER: begin
               if (lane == last_lane) begin
                  phase  <= PH_IDLE;
                  done_q <= 1'b1;
               end else begin
                  lane  <= lane + 2'd1;
                  phase <= PH_STROBE;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   logic        strobe;
   logic [15:0] lane_io;

   assign busy    = (phase != PH_IDLE);
   assign strobe  = (phase == PH_STROBE);
   assign done    = done_q;
   assign acc_err = err_q;

   assign nand_we_n   = !(strobe && wr_q);
   assign nand_re_n   = !(strobe && !wr_q);
   assign nand_cle    = busy && (kind_q == WK_CMD);
   assign nand_ale    = busy && (kind_q == WK_ADR);
   assign nand_io_oe  = busy && wr_q;
   assign nand_io_out = nand_io_oe ? lane_io : '0;

   for (genvar i = 0; i < NUM_CS; i++) begin : g_ce
      assign nand_ce_n[i] = !(busy && (cs_q == CS_W'(i)));
   end

   nwa_lane_mux u_mux (
      .lane (lane),
      .wide (wide_q),
      .wdata(wdata_q),
      .io   (lane_io)
   );

   nwa_read_pack u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (go),
      .cap      (strobe && !wr_q),
      .lane     (lane),
      .wide     (wide_q),
      .byte_only(byte_q),
      .io_in    (nand_io_in),
      .acc      (rd_data)
   );

   // R10: the two strobes are never low together
   p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));
   // R10: strobes only inside a busy sequence
   p_strobe_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_re_n) |-> busy);
   // R10: end of a sequence is marked by done
   p_done_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   // R3: latch enables are exclusive
   p_latch_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));
   // R3: read cycles carry neither latch enable
   p_read_no_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> (!nand_cle && !nand_ale));
   // R2: one chip enable at most, exactly one while busy
   p_ce_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~nand_ce_n));
   p_ce_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($countones(~nand_ce_n) == 1));
   // R9: an error never follows a device sequence
   p_err_no_seq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |-> (done && !$past(busy)));

endmodule

// File: tb/sim_nand_width_adapter.sv
module sim_nand_width_adapter;

   localparam int NUM_CS = 8;
   localparam int ADDR_W = 12;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                cpu_req = 1'b0;
   logic                cpu_wr = 1'b0;
   logic [ADDR_W-1:0]   cpu_addr = '0;
   logic [1:0]          cpu_size = '0;
   logic [31:0]         cpu_wdata = '0;
   logic [2*NUM_CS-1:0] cs_type = '0;
   logic [NUM_CS-1:0]   cs_wide = '0;
   logic                busy, done, acc_err;
   logic [31:0]         rd_data;
   logic [NUM_CS-1:0]   nand_ce_n;
   logic                nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
   logic [15:0]         nand_io_out;
   logic [15:0]         nand_io_in = '0;

   always #10 clk = ~clk;

   nand_width_adapter u0 (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
      .cpu_addr(cpu_addr), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
      .cs_type(cs_type), .cs_wide(cs_wide), .busy(busy), .done(done),
      .acc_err(acc_err), .rd_data(rd_data), .nand_ce_n(nand_ce_n),
      .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
      .nand_re_n(nand_re_n), .nand_io_oe(nand_io_oe),
      .nand_io_out(nand_io_out), .nand_io_in(nand_io_in)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   // device model: logs every strobe cycle, serves read data
   logic [63:0]       dev_stream = '0;
   int                sc = 0;
   int                sc_base = 0;
   int                mk;
   logic              s_rd [256];
   logic              s_cle[256];
   logic              s_ale[256];
   logic [NUM_CS-1:0] s_ce [256];
   logic [15:0]       s_io [256];

   always @(negedge clk) begin
      if (!nand_we_n || !nand_re_n) begin
         mk = sc - sc_base;
         if (mk < 0 || mk > 3) mk = 3;
         s_rd[sc % 256]  = !nand_re_n;
         s_cle[sc % 256] = nand_cle;
         s_ale[sc % 256] = nand_ale;
         s_ce[sc % 256]  = nand_ce_n;
         s_io[sc % 256]  = nand_io_out;
         if (!nand_re_n) nand_io_in = dev_stream[16*mk +: 16];
         sc = sc + 1;
      end
   end

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (cyc == 150000) begin
         n_chk = n_chk + 1;
         n_bad = n_bad + 1;
         $display("FAIL R10 watchdog actual=%0d expected<150000", cyc);
         summary();
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk = n_chk + 1;
      if (!ok) begin
         n_bad = n_bad + 1;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int exp_beats(input logic [1:0] sz, input logic wide);
      if (wide) return (sz >= 2'd2) ? 2 : 1;
      case (sz)
         2'd0:    return 1;
         2'd1:    return 2;
         default: return 4;
      endcase
   endfunction

   function automatic logic [11:0] win_addr(input int cs, input int win);
      return 12'(32'h60 + cs * 32'h30 + 32'h1C + win * 4 + $urandom_range(0, 3));
   endfunction

   task automatic launch(input bit wr, input logic [11:0] a, input logic [1:0] sz, input logic [31:0] wd);
      @(negedge clk);
      sc_base   = sc;
      cpu_req   = 1'b1;
      cpu_wr    = wr;
      cpu_addr  = a;
      cpu_size  = sz;
      cpu_wdata = wd;
      @(negedge clk);
      cpu_req   = 1'b0;
      cpu_wdata = $urandom;
      cpu_addr  = 12'($urandom);
   endtask

   task automatic wait_done(output int bc);
      int g = 0;
      bc = 0;
      while (!done && g < 200) begin
         if (busy) bc++;
         @(negedge clk);
         g++;
      end
      if (g >= 200) chk(1'b0, "R10 done timeout", 64'(g), 64'd0);
   endtask

   // win: 0 command, 1 address, 2 data, 3 outside (raw used)
   task automatic access(input bit wr, input int cs, input int win, input logic [1:0] sz,
                         input logic [31:0] wd, input logic [11:0] raw);
      logic [11:0] a;
      logic [1:0]  typ;
      logic        wide;
      bit          active;
      bit          e_err;
      int          n;
      int          bc;
      int          got;
      logic [31:0] er;
      string       tag;
      a      = (win < 3) ? win_addr(cs, win) : raw;
      typ    = cs_type[2*cs +: 2];
      wide   = cs_wide[cs];
      active = (win < 3) && (typ == 2'd2) && (wr || win == 2);
      n      = active ? exp_beats(sz, wide) : 0;
      e_err  = (win == 3) && (sz < 2'd2);
      if (!active)   tag = (win == 3) ? "R9" : "R8";
      else if (wide) tag = wr ? "R6" : "R7";
      else           tag = wr ? "R4" : "R5";
      er = '0;
      dev_stream = {$urandom, $urandom};
      for (int k = 0; k < n; k++) begin
         if (!wr) begin
            if (wide) begin
               if (sz == 2'd0) er[7:0] = dev_stream[7:0];
               else            er[16*k +: 16] = dev_stream[16*k +: 16];
            end else begin
               er[8*k +: 8] = dev_stream[16*k +: 8];
            end
         end
      end
      launch(wr, a, sz, wd);
      wait_done(bc);
      got = sc - sc_base;
      chk(got == n, {tag, " cycle count"}, 64'(got), 64'(n));
      chk(bc == 2*n, "R10 busy length", 64'(bc), 64'(2*n));
      chk(acc_err == e_err, "R9 error flag", 64'(acc_err), 64'(e_err));
      chk(rd_data == er, {tag, " read word"}, 64'(rd_data), 64'(er));
      for (int k = 0; k < n && k < got; k++) begin
         int ix = (sc_base + k) % 256;
         logic [15:0] eio = wide ? wd[16*k +: 16] : {8'h00, wd[8*k +: 8]};
         chk(s_rd[ix] == !wr, "R10 strobe kind", 64'(s_rd[ix]), 64'(!wr));
         chk(s_cle[ix] == (win == 0), "R3 CLE", 64'(s_cle[ix]), 64'(win == 0));
         chk(s_ale[ix] == (win == 1), "R3 ALE", 64'(s_ale[ix]), 64'(win == 1));
         chk(s_ce[ix] == ~(NUM_CS'(1) << cs), "R2 chip enable", 64'(s_ce[ix]), 64'(~(NUM_CS'(1) << cs)));
         if (wr) chk(s_io[ix] == eio, {tag, " write lane"}, 64'(s_io[ix]), 64'(eio));
      end
      @(negedge clk);
      chk(!done, "R10 done one clock", 64'(done), 64'd0);
   endtask

   initial begin
      int bc;
      int base;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !acc_err, "R1 flags", {busy, done, acc_err}, 0);
      chk(nand_we_n && nand_re_n, "R1 strobes", {nand_we_n, nand_re_n}, 2'b11);
      chk(!nand_cle && !nand_ale && !nand_io_oe, "R1 latches", {nand_cle, nand_ale, nand_io_oe}, 0);
      chk(nand_ce_n == '1, "R1 chip enables", 64'(nand_ce_n), 64'(8'hFF));
      chk(rd_data == 0, "R1 read word", 64'(rd_data), 0);
      rst_n = 1'b1;

      cs_type = {NUM_CS{2'b10}};
      cs_wide = '0;
      // 8-bit directed
      access(1, 0, 0, 2'd2, 32'hA1B2C3D4, '0);
      access(1, 7, 1, 2'd1, 32'h00005A3C, '0);
      access(1, 2, 2, 2'd0, 32'hFFFFFF77, '0);
      access(0, 3, 2, 2'd2, 32'h0, '0);
      access(0, 3, 2, 2'd0, 32'h0, '0);
      access(0, 4, 2, 2'd1, 32'h0, '0);
      // 16-bit directed
      cs_wide[5] = 1'b1;
      access(1, 5, 2, 2'd0, 32'h1234BEEF, '0);
      access(1, 5, 0, 2'd3, 32'hCAFE0B0E, '0);
      access(0, 5, 2, 2'd0, 32'h0, '0);
      access(0, 5, 2, 2'd1, 32'h0, '0);
      access(0, 5, 2, 2'd2, 32'h0, '0);
      // R8: non-NAND device type, and command/address reads
      cs_type[5:4] = 2'd1;
      access(1, 2, 0, 2'd2, 32'h11223344, '0);
      access(0, 2, 2, 2'd2, 32'h0, '0);
      cs_type[5:4] = 2'd2;
      access(0, 1, 0, 2'd1, 32'h0, '0);
      access(0, 1, 1, 2'd2, 32'h0, '0);
      // R9: outside the windows
      access(1, 0, 3, 2'd1, 32'h5, 12'h050);
      access(0, 0, 3, 2'd0, 32'h0, 12'h07B);
      access(1, 0, 3, 2'd2, 32'h5, 12'h1E4);
      access(0, 0, 3, 2'd2, 32'h0, 12'h0A8);

      // R10: request while busy is ignored
      launch(1, win_addr(1, 0), 2'd2, 32'h0BADF00D);
      base = sc_base;
      cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = win_addr(4, 2); cpu_size = 2'd2;
      @(negedge clk);
      cpu_req = 1'b0;
      wait_done(bc);
      repeat (4) @(negedge clk);
      chk(sc - base == 4, "R10 ignored request", 64'(sc - base), 64'd4);
      chk(!busy, "R10 idle after ignored", 64'(busy), 0);
      for (int k = 0; k < 4; k++) begin
         chk(!s_rd[(base + k) % 256] && s_ce[(base + k) % 256] == 8'hFD, "R10 ignored request cycles",
             64'(s_ce[(base + k) % 256]), 64'(8'hFD));
      end

      // R10: new request in the done clock
      dev_stream = 64'h0000_0000_9A55_1E3C;
      launch(0, win_addr(6, 2), 2'd1, 32'h0);
      wait_done(bc);
      chk(rd_data == 32'h0000_553C, "R5 first of back-to-back", 64'(rd_data), 64'h553C);
      base = sc;
      cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = win_addr(6, 1); cpu_size = 2'd0;
      cpu_wdata = 32'h0000_00C5;
      @(negedge clk);
      cpu_req = 1'b0;
      chk(busy, "R10 accepted in done clock", 64'(busy), 1);
      wait_done(bc);
      chk(sc - base == 1, "R10 second of back-to-back", 64'(sc - base), 1);
      chk(s_ale[base % 256] && !s_cle[base % 256] && s_io[base % 256] == 16'h00C5,
          "R3 second of back-to-back", 64'(s_io[base % 256]), 64'h00C5);
      chk(rd_data == 0, "R8 write leaves read word zero", 64'(rd_data), 0);

      // random mix
      for (int it = 0; it < 400; it++) begin
         int cs  = $urandom_range(0, NUM_CS - 1);
         int win = $urandom_range(0, 3);
         logic [11:0] raw;
         for (int c = 0; c < NUM_CS; c++) begin
            cs_type[2*c +: 2] = ($urandom_range(0, 3) != 0) ? 2'd2 : 2'($urandom_range(0, 3));
         end
         cs_wide = NUM_CS'($urandom);
         case ($urandom_range(0, 2))
            0:       raw = 12'(32'h60 + cs * 32'h30 + $urandom_range(0, 27));
            1:       raw = 12'(32'h1E0 + $urandom_range(0, 31));
            default: raw = 12'($urandom_range(0, 32'h5F));
         endcase
         access(1'($urandom), cs, win, 2'($urandom), $urandom, raw);
      end

      summary();
      $finish;
   end

endmodule